// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Flags

This block keeps four external interrupt flags in the upper half of one 8-bit special-function register. Each flag watches its own pin through a two-flop synchronizer and is set by one edge direction that is fixed for that pin. Once set, a flag stays set until software writes a 0 to it. Software may also write a 1 to set a flag. A flag set by software raises the same interrupt request as a flag set by a pin edge.

Each flag drives an interrupt request output that is gated by its own enable input. The lower four bits of the register belong to other logic. Reads of those bits return an external status input, and this block ignores writes to them. Reads and writes take effect only at the register's decoded address.

Flag index i (0..3) sits at register bit 4+i and belongs to interrupt source i+2. Pins, enables and requests use the same index order.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset all four flags read 0 and every interrupt request output is 0.
- R2: Flags at bits 7 and 5 (pin indices 3 and 1) are set by a 1-to-0 transition of their pin and are not set by a 0-to-1 transition.
- R3: Flags at bits 6 and 4 (pin indices 2 and 0) are set by a 0-to-1 transition of their pin and are not set by a 1-to-0 transition.
- R4: A pin level driven before clock edge n shows as a set flag after edge n+2, and the flag is still clear after edge n+1.
- R5: A set flag stays set through later pin activity in either direction, and when no write of 0 reaches it.
- R6: A write to address 0x91 loads data bits 7..4 into the flags, so a 0 clears a flag and a 1 sets it.
- R7: Each interrupt request output equals its flag ANDed with its enable input, whether the flag was set by a pin or by a write.
- R8: When a pin edge and a write of 0 reach the same flag in the same cycle, the flag ends up set.
- R9: A read at address 0x91 returns the flags in bits 7..4 and the external status input in bits 3..0; a read at any other address returns 0.
- R10: Writes to any address other than 0x91 change no flag, and write data bits 3..0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational from address |
| irq_pin | input | 4 | Asynchronous external interrupt pins |
| irq_en | input | 4 | Per-source request enable |
| ext_status | input | 4 | Status bits shown in register bits 3..0 |
| irq_req | output | 4 | Interrupt request per source |

## Verification
The two functions that can land on one flag in the same cycle are a synchronized pin edge and a software write. The bench provokes this by changing a pin and timing a write of 0 so that it reaches the register on the same edge as the detected transition. The flag must read 1 afterwards. Random runs mix pin toggles with writes at the register address and at other addresses. A bench model recomputes the flags every cycle from pin history and write strobes, and it judges these collisions in every cycle, not only in the directed case.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int unsigned NUM_SRC   = 4;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned FLAG_LSB  = REG_W - NUM_SRC;
  localparam logic [REG_W-1:0] DEF_ADDR = 8'h91;
  // 1 = flag sets on falling edge of that pin, 0 = rising edge
  localparam logic [NUM_SRC-1:0] DEF_FALL_MASK = 4'b1010;

  typedef logic [NUM_SRC-1:0] src_vec_t;
  typedef logic [REG_W-1:0]   reg_t;
endpackage

// File: rtl/eirq_rst_sync.sv
module eirq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/eirq_pin_edge.sv
module eirq_pin_edge #(
  parameter int unsigned STAGES  = 2,
  parameter bit          FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic edge_hit
);
  // Registers reset to the pin's idle level so release of reset makes no edge.
  localparam logic IDLE = FALLING;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              cur;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur = sync_q[STAGES-1];

  generate
    if (FALLING) begin : g_fall
      assign edge_hit = prev_q & ~cur;
    end else begin : g_rise
      assign edge_hit = ~prev_q & cur;
    end
  endgenerate
endmodule

// File: rtl/eirq_flag_bank.sv
module eirq_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_hw,
  input  logic         wr_en,
  input  logic [N-1:0] wr_val,
  output logic [N-1:0] flag_q
);
  logic [N-1:0] flag_d;
  logic         upd;

  // Hardware set is ORed in last, so an edge beats a same-cycle clear.
  always_comb begin
    if (wr_en) flag_d = wr_val | set_hw;
    else       flag_d = flag_q | set_hw;
    upd = wr_en | (|set_hw);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= '0;
    else if (upd) flag_q <= flag_d;
  end
endmodule

// File: rtl/eirq_sfr_port.sv
module eirq_sfr_port
  import eirq_pkg::*;
#(
  parameter reg_t ADDR = DEF_ADDR
) (
  input  reg_t     sfr_addr,
  input  logic     sfr_wr,
  input  src_vec_t flags,
  input  src_vec_t ext_status,
  output logic     wr_hit,
  output reg_t     sfr_rdata
);
  logic sel;

  always_comb begin
    sel       = (sfr_addr == ADDR);
    wr_hit    = sel & sfr_wr;
    sfr_rdata = sel ? {flags, ext_status} : '0;
  end
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
  import eirq_pkg::*;
#(
  parameter reg_t        SFR_ADDR    = DEF_ADDR,
  parameter int unsigned SYNC_STAGES = 2,
  parameter src_vec_t    FALL_MASK   = DEF_FALL_MASK
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic [3:0] irq_pin,
  input  logic [3:0] irq_en,
  input  logic [3:0] ext_status,
  output logic [3:0] irq_req
);
  logic     rst_n_sync;
  src_vec_t edge_hit;
  src_vec_t flag_q;
  logic     wr_hit;
  logic     wdata_lo_unused;

  assign wdata_lo_unused = ^sfr_wdata[FLAG_LSB-1:0];

  eirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pin
    eirq_pin_edge #(.STAGES(SYNC_STAGES), .FALLING(FALL_MASK[i])) u_edge (
      .clk(clk), .rst_n(rst_n_sync), .pin(irq_pin[i]), .edge_hit(edge_hit[i])
    );
  end

  eirq_sfr_port #(.ADDR(SFR_ADDR)) u_port (
    .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .flags(flag_q),
    .ext_status(ext_status), .wr_hit(wr_hit), .sfr_rdata(sfr_rdata)
  );

  eirq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n_sync), .set_hw(edge_hit), .wr_en(wr_hit),
    .wr_val(sfr_wdata[REG_W-1:FLAG_LSB]), .flag_q(flag_q)
  );

  assign irq_req = flag_q & irq_en;
endmodule

// File: rtl/ext_irq_flags_chk.sv
module ext_irq_flags_chk #(
  parameter logic [7:0] ADDR = 8'h91
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] sfr_addr,
  input logic       sfr_wr,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata,
  input logic [3:0] ext_status,
  input logic [3:0] irq_en,
  input logic [3:0] irq_req,
  input logic [3:0] flags,
  input logic [3:0] edge_hit,
  input logic       wr_hit
);
  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> ((flags & $past(flags)) == $past(flags)));

  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != 4'h0) |=> ((flags & $past(edge_hit)) == $past(edge_hit)));

  // R6
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && edge_hit == 4'h0) |=> (flags == $past(sfr_wdata[7:4])));

  // R10
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_hit) |-> ((flags & ~$past(flags) & ~$past(edge_hit)) == 4'h0));

  // R7
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~irq_en) == 4'h0);

  // R9
  read_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == ADDR) |-> (sfr_rdata[3:0] == ext_status));
endmodule

bind ext_irq_flags ext_irq_flags_chk #(.ADDR(SFR_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
  .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_status(ext_status),
  .irq_en(irq_en), .irq_req(irq_req), .flags(flag_q), .edge_hit(edge_hit),
  .wr_hit(wr_hit)
);

// File: tb/tb_ext_irq_flags.sv
module tb_ext_irq_flags;
  localparam logic [7:0] ADDR = 8'h91;
  localparam logic [3:0] FALL = 4'b1010;
  localparam logic [3:0] IDLE = FALL;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = ADDR;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic [3:0] irq_pin = IDLE;
  logic [3:0] irq_en = 4'h0;
  logic [3:0] ext_status = 4'h0;
  logic [3:0] irq_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string cur_tag = "R1";

  logic [3:0] ph [0:3];
  logic [3:0] exp_flags = 4'h0;

  always #4 clk = ~clk;

  ext_irq_flags dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_pin(irq_pin),
    .irq_en(irq_en), .ext_status(ext_status), .irq_req(irq_req)
  );

  function automatic logic [3:0] edges_of(input logic [3:0] old_v, input logic [3:0] new_v);
    return (FALL & old_v & ~new_v) | (~FALL & ~old_v & new_v);
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [3:0] f,
                                          input logic [3:0] st);
    return (a == ADDR) ? {f, st} : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, take the edge, update model, compare ports.
  task automatic cycle(input logic [3:0] pin, input logic wr, input logic [7:0] a,
                       input logic [7:0] wd, input logic [3:0] en, input logic [3:0] st);
    ph[3] = ph[2]; ph[2] = ph[1]; ph[1] = ph[0]; ph[0] = pin;
    irq_pin = pin; sfr_wr = wr; sfr_addr = a; sfr_wdata = wd;
    irq_en = en; ext_status = st;
    @(posedge clk); #1;
    if (wr && a == ADDR) exp_flags = wd[7:4];
    exp_flags = exp_flags | edges_of(ph[3], ph[2]);
    chk(cur_tag, sfr_rdata, exp_read(a, exp_flags, st));
    chk("R7", {4'h0, irq_req}, {4'h0, exp_flags & en});
  endtask

  task automatic idle(input logic [3:0] pin, input int n);
    for (int k = 0; k < n; k++) cycle(pin, 1'b0, ADDR, 8'h00, 4'hF, 4'h5);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) ph[k] = IDLE;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", sfr_rdata, 8'h00);
    chk("R1", {4'h0, irq_req}, 8'h00);
    idle(IDLE, 2);

    // R3 / R4: rising edge on index 0 (bit 4), exact latency
    cur_tag = "R4";
    cycle(IDLE | 4'b0001, 1'b0, ADDR, 8'h00, 4'hF, 4'h5);
    chk("R4", sfr_rdata & 8'hF0, 8'h00);
    cycle(IDLE | 4'b0001, 1'b0, ADDR, 8'h00, 4'hF, 4'h5);
    chk("R4", sfr_rdata & 8'hF0, 8'h00);
    cycle(IDLE | 4'b0001, 1'b0, ADDR, 8'h00, 4'hF, 4'h5);
    chk("R3", sfr_rdata & 8'hF0, 8'h10);
    // R5: pin back low, flag stays
    cur_tag = "R5";
    idle(IDLE, 5);
    chk("R5", sfr_rdata & 8'hF0, 8'h10);

    // R6: write 0 clears
    cur_tag = "R6";
    cycle(IDLE, 1'b1, ADDR, 8'h0F, 4'hF, 4'h5);
    chk("R6", sfr_rdata, 8'h05);
    // R2: falling edge on index 1 (bit 5) sets; rising back does not
    cur_tag = "R2";
    idle(4'b1000, 4);
    chk("R2", sfr_rdata & 8'hF0, 8'h20);
    cycle(IDLE, 1'b1, ADDR, 8'h00, 4'hF, 4'h5);
    idle(IDLE, 5);
    chk("R2", sfr_rdata & 8'hF0, 8'h00);
    // R3: falling of a rising-edge pin (index 2) does not set
    cur_tag = "R3";
    idle(IDLE | 4'b0100, 5);
    cycle(IDLE | 4'b0100, 1'b1, ADDR, 8'h00, 4'hF, 4'h5);
    idle(IDLE, 5);
    chk("R3", sfr_rdata & 8'hF0, 8'h00);

    // R6: write 1 sets all, R7 gating by enable
    cur_tag = "R6";
    cycle(IDLE, 1'b1, ADDR, 8'hF0, 4'b0110, 4'h9);
    chk("R6", sfr_rdata, 8'hF9);
    chk("R7", {4'h0, irq_req}, 8'h06);
    cur_tag = "R7";
    cycle(IDLE, 1'b0, ADDR, 8'h00, 4'b1001, 4'h9);
    chk("R7", {4'h0, irq_req}, 8'h09);

    // R10: other address write ignored; R9: other address reads 0
    cur_tag = "R10";
    cycle(IDLE, 1'b1, 8'h90, 8'h00, 4'hF, 4'h3);
    chk("R9", sfr_rdata, 8'h00);
    cycle(IDLE, 1'b0, ADDR, 8'h00, 4'hF, 4'h3);
    chk("R10", sfr_rdata, 8'hF3);
    cycle(IDLE, 1'b1, ADDR, 8'h0F, 4'hF, 4'hC);
    chk("R9", sfr_rdata, 8'h0C);

    // R8: edge on index 3 (falling) meets a write of 0 in the same cycle
    cur_tag = "R8";
    cycle(4'b0010, 1'b0, ADDR, 8'h00, 4'hF, 4'h0);
    cycle(4'b0010, 1'b0, ADDR, 8'h00, 4'hF, 4'h0);
    cycle(4'b0010, 1'b1, ADDR, 8'h00, 4'hF, 4'h0);
    chk("R8", sfr_rdata & 8'hF0, 8'h80);
    idle(IDLE, 4);

    // Random mix, fixed seed
    cur_tag = "R5";
    void'($urandom(32'h1234_5678));
    begin
      logic [3:0] pins;
      pins = IDLE;
      for (int n = 0; n < 4000; n++) begin
        logic       wr;
        logic [7:0] a;
        if ($urandom_range(3) == 0) pins = pins ^ 4'($urandom_range(15));
        wr = ($urandom_range(7) == 0);
        a  = ($urandom_range(3) == 0) ? 8'($urandom_range(255)) : ADDR;
        cycle(pins, wr, a, 8'($urandom), 4'($urandom), 4'($urandom));
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule